// File: doc/BRIEF.md
# Serial Receiver Deserializer with Word-Boundary Slip

This block turns one lane of serial bits into parallel words of `WIDTH` bits (2 to 10) for the core logic. A fast serial clock drives a right-shifting register and a load counter. Every `WIDTH` serial cycles, the counter copies the completed word into a load register. A slow parallel clock then samples that load register into the output register. The first serial bit of each word lands in the least significant bit of the word.

The word boundary never moves by itself. Only the user can move it, by raising `slip_req`. Each rising edge of that request, seen in the serial domain, holds the load counter still for one serial cycle while bits keep shifting in. Every later word boundary therefore lands one serial bit later. Two bypass modes skip deserialization entirely:
- Single-rate bypass gives a registered 1-bit output.
- Double-rate bypass captures a bit on each edge of the serial clock.

In both bypass modes, slip requests are ignored.

Top module: `serial_deser_slip`

## Requirements
- R1: In deserialize mode (`mode` 2'b00, or 2'b11 treated the same), the load register takes a new word on the `WIDTH`-th serial rising edge after reset is released, and then on every `WIDTH`-th edge. The word holds the last `WIDTH` bits sampled, with the earliest in bit 0.
- R2: On each `clk_par` rising edge in deserialize mode, `par_data` takes the content of the load register, and `par_valid` takes whether any word has been loaded since reset.
- R3: When `slip_req` is sampled high at a serial rising edge after being sampled low at the previous one, the load counter stalls at the next serial rising edge while the shift register keeps shifting. Every later load then happens one serial cycle later. A request held high causes exactly one slip.
- R4: The word boundary changes only through `slip_req`. Without requests, loads stay strictly periodic.
- R5: A synchronous active-high `rst`, held across at least one edge of each clock, clears the shift register, the load register, the counter and the output register. After reset, `par_data` is zero and `par_valid` is low until the first word has been loaded.
- R6: `mode` is changed only while `rst` is high.
- R7: In single-rate bypass (`mode` 2'b01), `par_data[0]` is `ser_in` as registered on each `clk_ser` rising edge, and the upper bits are zero. `par_valid` is high from the first serial rising edge after reset.
- R8: In double-rate bypass (`mode` 2'b10), `par_data[0]` holds the bit captured on the latest `clk_ser` rising edge and `par_data[1]` the bit captured on the latest falling edge. The upper bits are zero and `par_valid` is high after the first rising edge.
- R9: In both bypass modes, `slip_req` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Fast serial bit clock |
| clk_par | input | 1 | Slow parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit |
| slip_req | input | 1 | User request to move the word boundary by one bit |
| mode | input | 2 | 00 deserialize, 01 single-rate bypass, 10 double-rate bypass, 11 as 00 |
| par_data | output | WIDTH | Parallel word or bypass bits |
| par_valid | output | 1 | Output holds valid data |

## Verification
The deserializer is driven with a pseudo-random bit stream and a `WIDTH` of 4, so words and boundaries are dense and easy to tell apart.

Single-cycle slip pulses are placed at each of the four counter phases, including the phase where a load would occur. This exposes a wrong stall position, or a slip that drops or duplicates a bit. Slip requests held high for many cycles separate edge detection from level sensing.

The single-rate bypass is fed the same stream while `slip_req` toggles. The double-rate bypass gets every combination of rising-edge and falling-edge bits, which shows that the two capture edges are not swapped or merged.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int MAX_WORD_W = 10;

    typedef enum logic [1:0] {
        MODE_DESER = 2'b00,
        MODE_SDR   = 2'b01,
        MODE_DDR   = 2'b10,
        MODE_ALT   = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic fall_bit;
        logic rise_bit;
    } edge_pair_t;

    function automatic logic mode_is_bypass(input logic [1:0] m);
        return (m == MODE_SDR) || (m == MODE_DDR);
    endfunction

endpackage

// File: rtl/dsr_slip_ctl.sv
module dsr_slip_ctl (
    input  logic clk_ser,
    input  logic rst,
    input  logic slip_req,
    input  logic bypass,
    output logic slip_pulse
);
    logic samp_now;
    logic samp_old;

    // Sample the request, then detect its rising edge; held clear in bypass.
    always_ff @(posedge clk_ser) begin
        if (rst || bypass) begin
            samp_now <= 1'b0;
            samp_old <= 1'b0;
        end else begin
            samp_now <= slip_req;
            samp_old <= samp_now;
        end
    end

    assign slip_pulse = samp_now & ~samp_old & ~bypass;

endmodule

// File: rtl/dsr_shift_load.sv
module dsr_shift_load #(
    parameter int W = 8
) (
    input  logic                 clk_ser,
    input  logic                 rst,
    input  logic                 ser_bit,
    input  logic                 pause,
    output logic [W-1:0]         word,
    output logic                 loaded,
    output logic                 load_stb,
    output logic [$clog2(W)-1:0] cnt_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  shreg;
    logic [W-1:0]  shnext;
    logic [CW-1:0] cnt;

    // Right shift: the oldest bit ends up in bit 0.
    assign shnext   = {ser_bit, shreg[W-1:1]};
    assign load_stb = !pause && (cnt == LAST);
    assign cnt_o    = cnt;

    always_ff @(posedge clk_ser) begin
        if (rst) begin
            shreg  <= '0;
            word   <= '0;
            loaded <= 1'b0;
            cnt    <= '0;
        end else begin
            shreg <= shnext;
            if (!pause) begin
                if (cnt == LAST) begin
                    word   <= shnext;
                    loaded <= 1'b1;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dsr_bypass.sv
module dsr_bypass
    import dsr_pkg::*;
(
    input  logic       clk_ser,
    input  logic       rst,
    input  logic       ser_bit,
    output edge_pair_t pair,
    output logic       byp_valid
);
    logic rise_q;
    logic fall_q;

    always_ff @(posedge clk_ser) begin
        if (rst) begin
            rise_q    <= 1'b0;
            byp_valid <= 1'b0;
        end else begin
            rise_q    <= ser_bit;
            byp_valid <= 1'b1;
        end
    end

    always_ff @(negedge clk_ser) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= ser_bit;
    end

    assign pair = '{fall_bit: fall_q, rise_bit: rise_q};

endmodule

// File: rtl/serial_deser_slip.sv
module serial_deser_slip
    import dsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_ser,
    input  logic             clk_par,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             slip_req,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] par_data,
    output logic             par_valid
);
    localparam int CW = $clog2(WIDTH);

    rx_mode_e         mode_e;
    logic             bypass;
    logic             slip_pulse;
    logic [WIDTH-1:0] word_w;
    logic             loaded_w;
    logic             load_stb;
    logic [CW-1:0]    cnt_w;
    edge_pair_t       pair_w;
    logic             byp_valid;
    logic [WIDTH-1:0] par_q;
    logic             pv_q;

    assign mode_e = rx_mode_e'(mode);
    assign bypass = mode_is_bypass(mode);

    dsr_slip_ctl slip_i (
        .clk_ser    (clk_ser),
        .rst        (rst),
        .slip_req   (slip_req),
        .bypass     (bypass),
        .slip_pulse (slip_pulse)
    );

    dsr_shift_load #(.W(WIDTH)) shl_i (
        .clk_ser  (clk_ser),
        .rst      (rst),
        .ser_bit  (ser_in),
        .pause    (slip_pulse),
        .word     (word_w),
        .loaded   (loaded_w),
        .load_stb (load_stb),
        .cnt_o    (cnt_w)
    );

    dsr_bypass byp_i (
        .clk_ser   (clk_ser),
        .rst       (rst),
        .ser_bit   (ser_in),
        .pair      (pair_w),
        .byp_valid (byp_valid)
    );

    // Parallel-domain output register.
    always_ff @(posedge clk_par) begin
        if (rst) begin
            par_q <= '0;
            pv_q  <= 1'b0;
        end else begin
            par_q <= word_w;
            pv_q  <= loaded_w;
        end
    end

    always_comb begin
        par_data  = '0;
        par_valid = 1'b0;
        unique case (mode_e)
            MODE_SDR: begin
                par_data[0] = pair_w.rise_bit;
                par_valid   = byp_valid;
            end
            MODE_DDR: begin
                par_data[1:0] = {pair_w.fall_bit, pair_w.rise_bit};
                par_valid     = byp_valid;
            end
            default: begin
                par_data  = par_q;
                par_valid = pv_q;
            end
        endcase
    end

endmodule

// File: rtl/dsr_chk.sv
module dsr_chk #(
    parameter int W = 8
) (
    input logic                 clk_ser,
    input logic                 clk_par,
    input logic                 rst,
    input logic [1:0]           mode,
    input logic                 par_valid,
    input logic                 slip_pulse,
    input logic                 load_stb,
    input logic [$clog2(W)-1:0] cnt,
    input logic [W-1:0]         word
);
    a_r5_valid_low_after_reset: assert property (
        @(posedge clk_par) disable iff (rst)
        ((mode == 2'b00 || mode == 2'b11) && $past(rst)) |-> !par_valid);

    a_r1_load_spacing: assert property (
        @(posedge clk_ser) disable iff (rst)
        load_stb |=> !load_stb);

    a_r1_count_range: assert property (
        @(posedge clk_ser) disable iff (rst)
        int'(cnt) <= W - 1);

    a_r2_word_held: assert property (
        @(posedge clk_ser) disable iff (rst)
        !load_stb |=> $stable(word));

    a_r3_single_pulse: assert property (
        @(posedge clk_ser) disable iff (rst)
        slip_pulse |=> !slip_pulse);

    a_r3_count_stalls: assert property (
        @(posedge clk_ser) disable iff (rst)
        slip_pulse |=> (cnt == $past(cnt)));

endmodule

bind serial_deser_slip dsr_chk #(.W(WIDTH)) chk_i (
    .clk_ser    (clk_ser),
    .clk_par    (clk_par),
    .rst        (rst),
    .mode       (mode),
    .par_valid  (par_valid),
    .slip_pulse (slip_pulse),
    .load_stb   (load_stb),
    .cnt        (cnt_w),
    .word       (word_w)
);

// File: tb/serial_deser_slip_tb_top.sv
`timescale 1ns/1ps
module serial_deser_slip_tb_top;
    localparam int W = 4;

    logic         clk_ser = 1'b0;
    logic         clk_par = 1'b0;
    logic         rst = 1'b1;
    logic         ser_in = 1'b0;
    logic         slip_req = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] par_data;
    logic         par_valid;

    int checks = 0;
    int errors = 0;
    bit drive_auto = 1'b1;
    bit par_chk = 1'b1;
    int idx = 0;

    // Reference state, updated only at serial falling edges.
    logic [W-1:0] mh = '0;
    logic [W-1:0] mw = '0;
    logic         ml = 1'b0;
    int           mc = 0;
    logic         sp1 = 1'b0;
    logic         sp2 = 1'b0;
    logic [W-1:0] ew = '0;
    logic         ev = 1'b0;

    serial_deser_slip #(.WIDTH(W)) dut_i (
        .clk_ser   (clk_ser),
        .clk_par   (clk_par),
        .rst       (rst),
        .ser_in    (ser_in),
        .slip_req  (slip_req),
        .mode      (mode),
        .par_data  (par_data),
        .par_valid (par_valid)
    );

    // 200 MHz serial clock; parallel clock rises with every W-th serial edge.
    initial forever begin #2.5 clk_ser = 1'b1; #2.5 clk_ser = 1'b0; end
    initial begin
        #2.5;
        forever begin clk_par = 1'b1; #(W * 2.5); clk_par = 1'b0; #(W * 2.5); end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic sbit(input int i);
        return logic'(((i >> 1) ^ (i >> 3) ^ ((i * i) >> 2)) & 1);
    endfunction

    // Reference for the serial side, plus single-rate bypass checks.
    always @(negedge clk_ser) begin
        if (drive_auto) begin
            if (rst) begin
                mh = '0; mw = '0; ml = 1'b0; mc = 0; sp1 = 1'b0; sp2 = 1'b0;
            end else begin
                logic pz;
                logic is_byp;
                is_byp = (mode == 2'b01) || (mode == 2'b10);
                // R3: stall at the edge after a low-to-high sample of the request.
                pz = sp1 && !sp2 && !is_byp;
                sp2 = is_byp ? 1'b0 : sp1;
                sp1 = is_byp ? 1'b0 : slip_req;
                mh = {ser_in, mh[W-1:1]};
                if (!pz) begin
                    if (mc == W - 1) begin mw = mh; ml = 1'b1; mc = 0; end
                    else mc = mc + 1;
                end
                if (mode == 2'b01) begin
                    // R7 and R9: single-rate bypass follows ser_in whatever slip_req does.
                    chk(par_data == W'(ser_in), "R7/R9 sdr data", par_data, ser_in);
                    chk(par_valid == 1'b1, "R7 sdr valid", par_valid, 1);
                end
            end
            ser_in = sbit(idx);
            idx++;
        end
    end

    always @(posedge clk_par) begin
        ew = rst ? '0 : mw;
        ev = rst ? 1'b0 : ml;
    end

    // R1 R2 R3 R4 R5: parallel output against the reference word.
    always @(negedge clk_par) begin
        if (par_chk && (mode == 2'b00)) begin
            chk(par_data == ew, "R1/R2/R3/R4 word", par_data, ew);
            chk(par_valid == ev, "R2/R5 valid", par_valid, ev);
        end
    end

    task automatic ser_wait(input int n);
        repeat (n) @(negedge clk_ser);
        #1;
    endtask

    initial begin
        // R5: reset state.
        ser_wait(12);
        chk(par_data == '0, "R5 reset data", par_data, 0);
        chk(par_valid == 1'b0, "R5 reset valid", par_valid, 0);
        rst = 1'b0;
        ser_wait(40);
        for (int k = 0; k < 4; k++) begin
            // R3: single-cycle request at a different counter phase each time.
            slip_req = 1'b1;
            ser_wait(1);
            slip_req = 1'b0;
            ser_wait(10 + k);
            // R3: request held high causes one slip only.
            slip_req = 1'b1;
            ser_wait(9 + k);
            slip_req = 1'b0;
            ser_wait(13);
        end
        // R4: long run without requests.
        ser_wait(24);

        // R6: mode switched under reset; R7 and R9 with toggling slip_req.
        rst = 1'b1; par_chk = 1'b0; mode = 2'b01;
        ser_wait(3);
        rst = 1'b0;
        for (int i = 0; i < 24; i++) begin
            slip_req = ~slip_req;
            ser_wait(1);
        end
        slip_req = 1'b0;

        // R8: double-rate bypass, every rising/falling bit pair, with R9 slips.
        rst = 1'b1; mode = 2'b10; drive_auto = 1'b0;
        ser_wait(3);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            logic a;
            logic b;
            a = logic'(i & 1);
            b = logic'((i >> 1) & 1);
            slip_req = logic'((i >> 2) & 1);
            ser_in = a;
            @(posedge clk_ser); #1;
            ser_in = b;
            @(negedge clk_ser); #1;
            chk(par_data == W'({b, a}), "R8/R9 ddr data", par_data, {b, a});
            chk(par_valid == 1'b1, "R8 ddr valid", par_valid, 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule